// File: doc/BRIEF.md
# Drive Spin Policy Controller

This block chooses, from the measured access rate, whether a storage drive keeps spinning between accesses or goes to sleep. It also steps the drive through its power phases. It counts the accesses that start within each one-second window. When the window closes, it compares the count against a fixed break-even threshold. If the rate was high, the drive idles while still spinning. If the rate was low, the drive powers down as soon as it has no work left.

All durations are measured in millisecond ticks supplied from outside. A request that arrives while the drive is asleep first waits through a spin-up period and then runs an access of fixed length. A request that arrives while the drive is waking or busy is held in a single pending slot. That request is served straight after the current access. A grant pulse marks the start of each access and a done pulse marks its end.

Top module: `drive_spin_ctrl`

## Requirements
- R1: `pwr_state_o` encodes SLEEP as 0, WAKING as 1, ACCESS as 2 and IDLE as 3. In SLEEP, a request moves the state to WAKING at the next clock edge. The state moves to ACCESS at the edge that samples the WAKE_MS-th millisecond tick (default 20) seen while in WAKING. SLEEP never moves directly to ACCESS.
- R2: An access lasts ACC_MS millisecond ticks (default 10). `grant_o` is high for exactly the first cycle of every access. `done_o` is high for one cycle, the cycle right after the edge that samples the ACC_MS-th tick seen while in ACCESS.
- R3: With `keep_spin_o` high, an access that ends with nothing pending leads to IDLE. In IDLE, a request moves the state to ACCESS at the next edge, with a grant and without passing through WAKING.
- R4: With `keep_spin_o` low, an access that ends with nothing pending leads straight to SLEEP.
- R5: A request seen during WAKING or ACCESS sets a pending flag. When the current access ends, the pending access starts at once: the state stays ACCESS, and `done_o` and `grant_o` are high in the same cycle.
- R6: Only one request can be pending. Further requests seen while one is already pending merge with it, so they add exactly one extra access.
- R7: On a window tick, `keep_spin_o` becomes 1 exactly when at least KEEP_THR accesses (default 9) started in the closing window, and the count clears. An access that starts in the same cycle as the tick counts toward the new window.
- R8: The access counter saturates at its maximum (255 for 8 bits) instead of wrapping. A window with 260 accesses still sets `keep_spin_o`.
- R9: If `keep_spin_o` falls while the state is IDLE and no request is present, the state becomes SLEEP one clock edge later.
- R10: After reset the state is SLEEP and `keep_spin_o`, `grant_o`, `done_o` and `drive_on_o` are low. `drive_on_o` is high in every state except SLEEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | One-cycle access request strobe |
| ms_tick_i | input | 1 | One-cycle pulse each millisecond |
| win_tick_i | input | 1 | One-cycle pulse closing each one-second window |
| pwr_state_o | output | 2 | Drive phase: 0 SLEEP, 1 WAKING, 2 ACCESS, 3 IDLE |
| drive_on_o | output | 1 | Drive power enable, low only in SLEEP |
| grant_o | output | 1 | First cycle of an access |
| done_o | output | 1 | Access just completed |
| keep_spin_o | output | 1 | Keep-spinning policy from the last window |

## Verification
Faults in the phase counter show up at the ports within one access. A grant or done pulse that arrives one tick early or late is visible right away. A pending flag that gets lost or duplicated changes the number of grant pulses before the drive returns to SLEEP. A fault in the rate counter stays hidden until the next window tick, when it appears as a wrong `keep_spin_o`. Its effect on the phase becomes visible at the end of the following access, as IDLE where SLEEP was due or the other way round.

// File: rtl/spin_pkg.sv
package spin_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP  = 2'd0,
    ST_WAKING = 2'd1,
    ST_ACCESS = 2'd2,
    ST_IDLE   = 2'd3
  } spin_state_e;

  function automatic logic state_timed(input spin_state_e s);
    return (s == ST_WAKING) || (s == ST_ACCESS);
  endfunction

endpackage

// File: rtl/spin_timer.sv
module spin_timer #(
  parameter int WAKE_MS = 20,
  parameter int ACC_MS  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  input  logic sel_acc_i,
  input  logic ms_tick_i,
  output logic expire_o
);
  localparam int MAXD = (WAKE_MS > ACC_MS) ? WAKE_MS : ACC_MS;
  localparam int TW   = $clog2(MAXD + 1);
  localparam logic [TW-1:0] WAKE_LAST = TW'(WAKE_MS - 1);
  localparam logic [TW-1:0] ACC_LAST  = TW'(ACC_MS - 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] last_w;

  function automatic logic [TW-1:0] pick_last(input logic acc);
    return acc ? ACC_LAST : WAKE_LAST;
  endfunction

  assign last_w   = pick_last(sel_acc_i);
  assign expire_o = run_i && ms_tick_i && (cnt_q == last_w);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load_i)           cnt_q <= '0;
    else if (run_i && ms_tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assert_timer_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= last_w));

endmodule

// File: rtl/spin_rate_meter.sv
module spin_rate_meter #(
  parameter int CNT_W    = 8,
  parameter int KEEP_THR = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic win_i,
  output logic keep_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] THR     = CNT_W'(KEEP_THR);

  logic [CNT_W-1:0] cnt_q;
  logic             keep_q;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  function automatic logic busy_enough(input logic [CNT_W-1:0] v);
    return v >= THR;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      keep_q <= 1'b0;
    end else if (win_i) begin
      keep_q <= busy_enough(cnt_q);
      cnt_q  <= start_i ? CNT_W'(1) : '0;
    end else if (start_i) begin
      cnt_q  <= sat_inc(cnt_q);
    end
  end

  assign keep_o = keep_q;

  assert_cnt_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !win_i) |=> (cnt_q == CNT_MAX));

  assert_window_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_i && !start_i) |=> (cnt_q == '0));

endmodule

// File: rtl/spin_fsm.sv
module spin_fsm
  import spin_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  logic        keep_i,
  input  logic        expire_i,
  output spin_state_e state_o,
  output logic        load_o,
  output logic        run_o,
  output logic        sel_acc_o,
  output logic        start_acc_o,
  output logic        acc_end_o,
  output logic        grant_o,
  output logic        done_o
);
  spin_state_e state_q, state_n;
  logic pend_q, pend_n;
  logic start_wake_w, start_acc_w, acc_end_w, wake_end_w;
  logic grant_q, done_q;

  assign acc_end_w  = (state_q == ST_ACCESS) && expire_i;
  assign wake_end_w = (state_q == ST_WAKING) && expire_i;

  always_comb begin
    state_n      = state_q;
    start_wake_w = 1'b0;
    start_acc_w  = 1'b0;
    pend_n       = 1'b0;
    unique case (state_q)
      ST_SLEEP: begin
        if (req_i) begin
          state_n      = ST_WAKING;
          start_wake_w = 1'b1;
        end
      end
      ST_WAKING: begin
        pend_n = pend_q | req_i;
        if (wake_end_w) begin
          state_n     = ST_ACCESS;
          start_acc_w = 1'b1;
        end
      end
      ST_ACCESS: begin
        pend_n = pend_q | req_i;
        if (acc_end_w) begin
          if (pend_q || req_i) begin
            start_acc_w = 1'b1;
            pend_n      = 1'b0;
          end else if (keep_i) begin
            state_n = ST_IDLE;
          end else begin
            state_n = ST_SLEEP;
          end
        end
      end
      ST_IDLE: begin
        if (req_i) begin
          state_n     = ST_ACCESS;
          start_acc_w = 1'b1;
        end else if (!keep_i) begin
          state_n = ST_SLEEP;
        end
      end
      default: state_n = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_SLEEP;
      pend_q  <= 1'b0;
      grant_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      pend_q  <= pend_n;
      grant_q <= start_acc_w;
      done_q  <= acc_end_w;
    end
  end

  assign state_o     = state_q;
  assign load_o      = start_wake_w | start_acc_w;
  assign run_o       = state_timed(state_q);
  assign sel_acc_o   = (state_q == ST_ACCESS);
  assign start_acc_o = start_acc_w;
  assign acc_end_o   = acc_end_w;
  assign grant_o     = grant_q;
  assign done_o      = done_q;

  assert_sleep_wakes_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP) |=> (state_q == ST_SLEEP || state_q == ST_WAKING));

  assert_grant_in_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> (state_q == ST_ACCESS));

  assert_idle_when_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_end_w && !pend_q && !req_i && keep_i) |=> (state_q == ST_IDLE));

  assert_sleep_when_slow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_end_w && !pend_q && !req_i && !keep_i) |=> (state_q == ST_SLEEP));

  assert_pending_served_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_end_w && pend_q) |=> (state_q == ST_ACCESS && grant_o && done_o));

  assert_idle_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !keep_i && !req_i) |=> (state_q == ST_SLEEP));

endmodule

// File: rtl/drive_spin_ctrl.sv
module drive_spin_ctrl
  import spin_pkg::*;
#(
  parameter int WAKE_MS  = 20,
  parameter int ACC_MS   = 10,
  parameter int CNT_W    = 8,
  parameter int KEEP_THR = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       ms_tick_i,
  input  logic       win_tick_i,
  output logic [1:0] pwr_state_o,
  output logic       drive_on_o,
  output logic       grant_o,
  output logic       done_o,
  output logic       keep_spin_o
);
  spin_state_e state_w;
  logic keep_w, expire_w, load_w, run_w, sel_acc_w, start_acc_w, acc_end_w;

  spin_rate_meter #(.CNT_W(CNT_W), .KEEP_THR(KEEP_THR)) u_meter (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_acc_w),
    .win_i   (win_tick_i),
    .keep_o  (keep_w)
  );

  spin_timer #(.WAKE_MS(WAKE_MS), .ACC_MS(ACC_MS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_w),
    .run_i     (run_w),
    .sel_acc_i (sel_acc_w),
    .ms_tick_i (ms_tick_i),
    .expire_o  (expire_w)
  );

  spin_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .keep_i      (keep_w),
    .expire_i    (expire_w),
    .state_o     (state_w),
    .load_o      (load_w),
    .run_o       (run_w),
    .sel_acc_o   (sel_acc_w),
    .start_acc_o (start_acc_w),
    .acc_end_o   (acc_end_w),
    .grant_o     (grant_o),
    .done_o      (done_o)
  );

  assign pwr_state_o = state_w;
  assign drive_on_o  = (state_w != ST_SLEEP);
  assign keep_spin_o = keep_w;

  assert_done_after_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_end_w |=> done_o);

  assert_power_follows_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> drive_on_o);

endmodule

// File: tb/drive_spin_ctrl_tb.sv
`timescale 1ns/1ps
module drive_spin_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, ms = 1'b0, win = 1'b0;
  logic [1:0] pst;
  logic drv_on, grant, done, keep;
  int checks = 0;
  int errors = 0;
  int grant_cnt = 0;
  bit finished = 1'b0;

  localparam int TBL_N = 7;
  localparam int TBL [TBL_N][2] = '{'{3,0}, '{9,1}, '{8,0}, '{12,1}, '{0,0}, '{260,1}, '{1,0}};

  always #4 clk = ~clk;

  drive_spin_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ms_tick_i(ms), .win_tick_i(win),
    .pwr_state_o(pst), .drive_on_o(drv_on), .grant_o(grant), .done_o(done),
    .keep_spin_o(keep)
  );

  always @(negedge clk) if (grant) grant_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_req();
    req = 1'b1; step(); req = 1'b0;
  endtask

  task automatic pulse_ms();
    ms = 1'b1; step(); ms = 1'b0;
  endtask

  task automatic pulse_win();
    win = 1'b1; step(); win = 1'b0;
  endtask

  task automatic run_ms(input int n);
    for (int i = 0; i < n; i++) pulse_ms();
  endtask

  task automatic do_access();
    pulse_req();
    for (int i = 0; i < 40 && !done; i++) pulse_ms();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    // R10 reset state
    chk("R10 state", pst, 0);
    chk("R10 keep", keep, 0);
    chk("R10 grant", grant, 0);
    chk("R10 done", done, 0);
    chk("R10 drive_on", drv_on, 0);

    // R1 wake sequence
    pulse_req();
    chk("R1 waking", pst, 1);
    chk("R10 drive_on waking", drv_on, 1);
    run_ms(19);
    chk("R1 still waking", pst, 1);
    chk("R1 no early grant", grant, 0);
    pulse_ms();
    chk("R1 access", pst, 2);
    chk("R2 grant", grant, 1);
    step();
    chk("R2 grant one cycle", grant, 0);
    // R2 access length, R4 sleep after
    run_ms(9);
    chk("R2 still access", pst, 2);
    chk("R2 no early done", done, 0);
    pulse_ms();
    chk("R2 done", done, 1);
    chk("R4 sleep", pst, 0);

    // R5 pending during access
    pulse_req();
    run_ms(20);
    run_ms(3);
    pulse_req();
    run_ms(6);
    pulse_ms();
    chk("R5 done", done, 1);
    chk("R5 grant", grant, 1);
    chk("R5 stays access", pst, 2);
    run_ms(10);
    chk("R5 second done", done, 1);
    chk("R5 sleep", pst, 0);

    // R6 merged requests (one during waking, two during access)
    grant_cnt = 0;
    pulse_req();
    run_ms(5);
    pulse_req();
    run_ms(15);
    pulse_req();
    pulse_req();
    for (int i = 0; i < 80 && pst != 0; i++) pulse_ms();
    chk("R6 grants", grant_cnt, 2);

    // R3 keep spinning, idle, direct access
    pulse_win();
    for (int i = 0; i < 9; i++) do_access();
    pulse_win();
    chk("R7 keep set at 9", keep, 1);
    do_access();
    chk("R3 idle", pst, 3);
    pulse_req();
    chk("R3 direct access", pst, 2);
    chk("R3 grant", grant, 1);
    run_ms(10);
    chk("R3 back idle", pst, 3);
    // R9 keep drops in idle
    pulse_win();
    chk("R7 keep cleared", keep, 0);
    step();
    chk("R9 sleep", pst, 0);

    // R7 access coinciding with tick counts for new window
    pulse_win();
    for (int i = 0; i < 8; i++) do_access();
    pulse_req();
    run_ms(19);
    ms = 1'b1; win = 1'b1; step(); ms = 1'b0; win = 1'b0;
    chk("R7 coincident grant", grant, 1);
    chk("R7 eight not enough", keep, 0);
    run_ms(10);
    for (int i = 0; i < 8; i++) do_access();
    pulse_win();
    chk("R7 coincident counted", keep, 1);

    // table walk: R7 threshold, R8 saturation
    for (int t = 0; t < TBL_N; t++) begin
      pulse_win();
      for (int k = 0; k < TBL[t][0]; k++) do_access();
      pulse_win();
      chk($sformatf("R7 R8 table entry %0d", t), keep, TBL[t][1]);
    end
    step();
    chk("R9 final sleep", pst, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule